// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block forms the next control-store address for a microprogrammed controller. The address is 12 bits wide. It is held as a 4-bit page register (`w_q`) and an 8-bit offset register (`x_q`). The full address is `{w_q, x_q}`.

On every clock edge the block computes the next address from three kinds of input:
- the next-address fields of the current microword;
- a page-control code;
- a set of datapath test results, which arrive as plain signals.

The upper six offset bits are taken directly from a microword field. Each of the two lowest offset bits has its own condition selector. Each selector picks a constant or one datapath test signal, and this gives a four-way branch in a single cycle.

The page register keeps its value unless the microword changes it. It can be changed in three ways:
- it is loaded from an emit field;
- it is loaded from an immediate field through one special code of the bit-0 selector, which also forces that bit to 1;
- it is restored together with the offset from a pair of backup registers.

A forced-address input lets a trap overwrite the whole next address.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `w_q` and `x_q` both become 0 on that edge.
- R2: Unless a forced address or a restore applies, `x_q[7:2]` takes the value of `nxt_lo6` on the clock edge.
- R3: `sel_b1` chooses `x_q[1]` as follows: 0 gives constant 0, 1 gives constant 1, 2 gives `r_bit0`, 3 gives `v67_zero`, 4 gives `alu_c0` and 5 gives `sg_bit`.
- R4: `sel_b0` chooses `x_q[0]` as follows: 0 gives constant 0, 1 gives constant 1, 3 gives `r_dec_ok`, 4 gives `alu_c1`, 5 gives `z_zero`, 6 gives `sg_bit` and 7 gives `irq_any`.
- R5: `sel_b0` = 2 loads `w_q` from `imm_w` and sets `x_q[0]` to 1. This code takes precedence over a page-control emit load.
- R6: When `pg_ctl` is 0 and `sel_b0` is not 2, `w_q` keeps its value.
- R7: When `pg_ctl` is 1 and `sel_b0` is not 2, `w_q` is loaded from `emit`.
- R8: When `pg_ctl` is 2, `w_q` is loaded from `bak_w` and `x_q` from `bak_x`. This overrides every microword field and both condition selectors.
- R9: Encodings that are not defined give 0: `sel_b1` 6 to 15 and `sel_b0` 8 to 15. `pg_ctl` = 3 behaves as hold.
- R10: When `force_en` is 1, `{w_q, x_q}` becomes `force_addr` on the edge. This has priority over all other controls except reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_lo6 | input | 6 | Microword field that gives offset bits 7..2 |
| sel_b1 | input | 4 | Condition selector for offset bit 1 |
| sel_b0 | input | 4 | Condition selector for offset bit 0 |
| pg_ctl | input | 2 | Page control: 0 hold, 1 emit load, 2 restore from backup, 3 hold |
| emit | input | 4 | Emit field used to load the page |
| imm_w | input | 4 | Immediate page field used by `sel_b0` = 2 |
| bak_w | input | 4 | Backup page value |
| bak_x | input | 8 | Backup offset value |
| r_bit0 | input | 1 | Bit 0 of the R register |
| v67_zero | input | 1 | Bits 6 and 7 of the V register are both zero |
| alu_c0 | input | 1 | Carry out of ALU position 0 |
| alu_c1 | input | 1 | Carry out of ALU position 1 |
| r_dec_ok | input | 1 | R holds valid decimal digits |
| z_zero | input | 1 | Z bus is all zero |
| sg_bit | input | 1 | Selected S or G register bit |
| irq_any | input | 1 | Any interrupt pending |
| force_en | input | 1 | Override the next address |
| force_addr | input | 12 | Address loaded when `force_en` is 1 |
| w_q | output | 4 | Page register |
| x_q | output | 8 | Offset register |

## Verification
The assertions assume that every input is at a known level at each rising edge once reset has been released. They also assume that reset is held for at least one edge before the first check.

Several controls may be active in the same cycle. The properties encode the priority order among them: force, then restore, then the immediate page load, then the emit load. The stimulus deliberately sets competing controls together so that each priority is observed.

All inputs change only one time unit after a rising edge. Results are sampled one time unit after the following edge. This keeps stimulus and sampling clear of the edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [3:0] {
    B1_ZERO  = 4'd0,
    B1_ONE   = 4'd1,
    B1_RBIT0 = 4'd2,
    B1_V67Z  = 4'd3,
    B1_C0    = 4'd4,
    B1_SG    = 4'd5
  } b1_sel_e;

  typedef enum logic [3:0] {
    B0_ZERO  = 4'd0,
    B0_ONE   = 4'd1,
    B0_IMMW  = 4'd2,
    B0_DEC   = 4'd3,
    B0_C1    = 4'd4,
    B0_ZZ    = 4'd5,
    B0_SG    = 4'd6,
    B0_IRQ   = 4'd7
  } b0_sel_e;

  typedef enum logic [1:0] {
    PG_HOLD    = 2'd0,
    PG_EMIT    = 2'd1,
    PG_RESTORE = 2'd2,
    PG_SPARE   = 2'd3
  } pg_ctl_e;

  typedef struct packed {
    logic r_bit0;
    logic v67_zero;
    logic alu_c0;
    logic alu_c1;
    logic r_dec_ok;
    logic z_zero;
    logic sg_bit;
    logic irq_any;
  } test_bus_t;
endpackage

// File: rtl/useq_cond_b1.sv
module useq_cond_b1
  import useq_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  test_bus_t        tst,
  output logic             bit_o
);
  always_comb begin
    case (sel)
      SEL_W'(B1_ZERO):  bit_o = 1'b0;
      SEL_W'(B1_ONE):   bit_o = 1'b1;
      SEL_W'(B1_RBIT0): bit_o = tst.r_bit0;
      SEL_W'(B1_V67Z):  bit_o = tst.v67_zero;
      SEL_W'(B1_C0):    bit_o = tst.alu_c0;
      SEL_W'(B1_SG):    bit_o = tst.sg_bit;
      default:          bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_cond_b0.sv
module useq_cond_b0
  import useq_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  test_bus_t        tst,
  output logic             bit_o,
  output logic             imm_ld
);
  always_comb begin
    imm_ld = 1'b0;
    case (sel)
      SEL_W'(B0_ZERO): bit_o = 1'b0;
      SEL_W'(B0_ONE):  bit_o = 1'b1;
      SEL_W'(B0_IMMW): begin
        bit_o  = 1'b1;
        imm_ld = 1'b1;
      end
      SEL_W'(B0_DEC):  bit_o = tst.r_dec_ok;
      SEL_W'(B0_C1):   bit_o = tst.alu_c1;
      SEL_W'(B0_ZZ):   bit_o = tst.z_zero;
      SEL_W'(B0_SG):   bit_o = tst.sg_bit;
      SEL_W'(B0_IRQ):  bit_o = tst.irq_any;
      default:         bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_page_sel.sv
module useq_page_sel
  import useq_pkg::*;
#(
  parameter int HI_W = 4
) (
  input  logic [1:0]      pg_ctl,
  input  logic            imm_ld,
  input  logic [HI_W-1:0] imm_w,
  input  logic [HI_W-1:0] emit,
  input  logic [HI_W-1:0] w_cur,
  output logic [HI_W-1:0] w_nxt
);
  always_comb begin
    if (imm_ld)
      w_nxt = imm_w;
    else if (pg_ctl == PG_EMIT)
      w_nxt = emit;
    else
      w_nxt = w_cur;
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int HI_W  = 4,
  parameter int FLD_W = 6,
  parameter int SEL_W = 4,
  localparam int LO_W   = FLD_W + 2,
  localparam int ADDR_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLD_W-1:0]  nxt_lo6,
  input  logic [SEL_W-1:0]  sel_b1,
  input  logic [SEL_W-1:0]  sel_b0,
  input  logic [1:0]        pg_ctl,
  input  logic [HI_W-1:0]   emit,
  input  logic [HI_W-1:0]   imm_w,
  input  logic [HI_W-1:0]   bak_w,
  input  logic [LO_W-1:0]   bak_x,
  input  logic              r_bit0,
  input  logic              v67_zero,
  input  logic              alu_c0,
  input  logic              alu_c1,
  input  logic              r_dec_ok,
  input  logic              z_zero,
  input  logic              sg_bit,
  input  logic              irq_any,
  input  logic              force_en,
  input  logic [ADDR_W-1:0] force_addr,
  output logic [HI_W-1:0]   w_q,
  output logic [LO_W-1:0]   x_q
);
  test_bus_t       tst;
  logic            b1, b0, imm_ld;
  logic [HI_W-1:0] w_pg;
  logic [HI_W-1:0] w_d;
  logic [LO_W-1:0] x_d;

  assign tst = '{r_bit0: r_bit0, v67_zero: v67_zero, alu_c0: alu_c0,
                 alu_c1: alu_c1, r_dec_ok: r_dec_ok, z_zero: z_zero,
                 sg_bit: sg_bit, irq_any: irq_any};

  useq_cond_b1 #(.SEL_W(SEL_W)) u_b1 (.sel(sel_b1), .tst(tst), .bit_o(b1));
  useq_cond_b0 #(.SEL_W(SEL_W)) u_b0 (.sel(sel_b0), .tst(tst), .bit_o(b0), .imm_ld(imm_ld));
  useq_page_sel #(.HI_W(HI_W)) u_pg (
    .pg_ctl(pg_ctl), .imm_ld(imm_ld), .imm_w(imm_w),
    .emit(emit), .w_cur(w_q), .w_nxt(w_pg)
  );

  always_comb begin
    if (force_en) begin
      {w_d, x_d} = force_addr;
    end else if (pg_ctl == PG_RESTORE) begin
      w_d = bak_w;
      x_d = bak_x;
    end else begin
      w_d = w_pg;
      x_d = {nxt_lo6, b1, b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= '0;
      x_q <= '0;
    end else begin
      w_q <= w_d;
      x_q <= x_d;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (w_q == '0 && x_q == '0)); // R1
  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (rst)
    force_en |=> {w_q, x_q} == $past(force_addr)); // R10
  AST_RESTORE_BOTH: assert property (@(posedge clk) disable iff (rst)
    (!force_en && pg_ctl == PG_RESTORE) |=> (w_q == $past(bak_w) && x_q == $past(bak_x))); // R8
  AST_FIELD_BITS: assert property (@(posedge clk) disable iff (rst)
    (!force_en && pg_ctl != PG_RESTORE) |=> x_q[LO_W-1:2] == $past(nxt_lo6)); // R2
  AST_IMM_PAGE: assert property (@(posedge clk) disable iff (rst)
    (!force_en && pg_ctl != PG_RESTORE && sel_b0 == SEL_W'(B0_IMMW))
    |=> (x_q[0] && w_q == $past(imm_w))); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!force_en && (pg_ctl == PG_HOLD || pg_ctl == PG_SPARE) && sel_b0 != SEL_W'(B0_IMMW))
    |=> $stable(w_q)); // R6
  AST_UNUSED_B1: assert property (@(posedge clk) disable iff (rst)
    (!force_en && pg_ctl != PG_RESTORE && sel_b1 > SEL_W'(B1_SG)) |=> !x_q[1]); // R9
endmodule

// File: tb/useq_next_addr_tb_top.sv
module useq_next_addr_tb_top;
  logic clk = 0;
  logic rst;
  logic [5:0] nxt_lo6;
  logic [3:0] sel_b1, sel_b0, emit, imm_w, bak_w;
  logic [1:0] pg_ctl;
  logic [7:0] bak_x;
  logic r_bit0, v67_zero, alu_c0, alu_c1, r_dec_ok, z_zero, sg_bit, irq_any;
  logic force_en;
  logic [11:0] force_addr;
  logic [3:0] w_q;
  logic [7:0] x_q;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  useq_next_addr dut_i (
    .clk(clk), .rst(rst), .nxt_lo6(nxt_lo6), .sel_b1(sel_b1), .sel_b0(sel_b0),
    .pg_ctl(pg_ctl), .emit(emit), .imm_w(imm_w), .bak_w(bak_w), .bak_x(bak_x),
    .r_bit0(r_bit0), .v67_zero(v67_zero), .alu_c0(alu_c0), .alu_c1(alu_c1),
    .r_dec_ok(r_dec_ok), .z_zero(z_zero), .sg_bit(sg_bit), .irq_any(irq_any),
    .force_en(force_en), .force_addr(force_addr), .w_q(w_q), .x_q(x_q)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic set_status(input logic [7:0] p);
    {r_bit0, v67_zero, alu_c0, alu_c1, r_dec_ok, z_zero, sg_bit, irq_any} = p;
  endtask

  function automatic logic exp_b1(input int code);
    case (code)
      0: return 1'b0;
      1: return 1'b1;
      2: return r_bit0;
      3: return v67_zero;
      4: return alu_c0;
      5: return sg_bit;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_b0(input int code);
    case (code)
      0: return 1'b0;
      1: return 1'b1;
      2: return 1'b1;
      3: return r_dec_ok;
      4: return alu_c1;
      5: return z_zero;
      6: return sg_bit;
      7: return irq_any;
      default: return 1'b0;
    endcase
  endfunction

  task automatic idle();
    nxt_lo6 = 0; sel_b1 = 0; sel_b0 = 0; pg_ctl = 0; emit = 0; imm_w = 0;
    bak_w = 0; bak_x = 0; force_en = 0; force_addr = 0; set_status(8'h00);
  endtask

  task automatic t_reset();
    rst = 1; nxt_lo6 = 6'h3F; sel_b1 = 1; sel_b0 = 1; pg_ctl = 1; emit = 4'hF;
    cyc();
    chk("R1 reset", {w_q, x_q}, 12'h000);
    rst = 0; idle();
  endtask

  task automatic t_field();
    nxt_lo6 = 6'h2A; cyc();
    chk("R2 field", {w_q, x_q}, 12'h0A8);
    nxt_lo6 = 6'h15; sel_b1 = 1; sel_b0 = 1; cyc();
    chk("R2 field ones", {w_q, x_q}, 12'h057);
  endtask

  task automatic t_sel_sweep(input logic [7:0] pat);
    set_status(pat);
    nxt_lo6 = 6'h01;
    for (int c = 0; c < 16; c++) begin
      sel_b1 = c[3:0];
      sel_b0 = (c == 2) ? 4'd0 : c[3:0];
      cyc();
      chk(c > 5 ? "R9 b1 unused" : "R3 b1 select", {11'b0, x_q[1]}, {11'b0, exp_b1(c)});
      chk(c > 7 ? "R9 b0 unused" : "R4 b0 select", {11'b0, x_q[0]},
          {11'b0, exp_b0((c == 2) ? 0 : c)});
    end
    sel_b1 = 0; sel_b0 = 0;
  endtask

  task automatic t_emit_hold();
    pg_ctl = 1; emit = 4'hC; nxt_lo6 = 6'h00; cyc();
    chk("R7 emit load", {w_q, x_q}, 12'hC00);
    pg_ctl = 0; emit = 4'h3; sel_b0 = 1; cyc();
    chk("R6 page hold", {w_q, x_q}, 12'hC01);
    pg_ctl = 3; cyc();
    chk("R9 spare ctl holds", {w_q, x_q}, 12'hC01);
    sel_b0 = 0; pg_ctl = 0;
  endtask

  task automatic t_imm();
    sel_b0 = 2; imm_w = 4'h5; pg_ctl = 1; emit = 4'h9; nxt_lo6 = 6'h10; cyc();
    chk("R5 imm page beats emit", {w_q, x_q}, 12'h541);
    sel_b0 = 0; pg_ctl = 0; cyc();
    chk("R6 hold after imm", {w_q, x_q}, 12'h540);
  endtask

  task automatic t_restore();
    pg_ctl = 2; bak_w = 4'h3; bak_x = 8'h5E; nxt_lo6 = 6'h3F; sel_b1 = 1; sel_b0 = 2;
    imm_w = 4'hA; cyc();
    chk("R8 restore", {w_q, x_q}, 12'h35E);
    pg_ctl = 0; sel_b1 = 0; sel_b0 = 0;
  endtask

  task automatic t_force();
    force_en = 1; force_addr = 12'h7F1; pg_ctl = 2; bak_w = 4'h1; bak_x = 8'h22; cyc();
    chk("R10 force over restore", {w_q, x_q}, 12'h7F1);
    pg_ctl = 0; sel_b0 = 2; imm_w = 4'hB; force_addr = 12'h0C4; cyc();
    chk("R10 force over imm", {w_q, x_q}, 12'h0C4);
    force_en = 0; sel_b0 = 0;
    rst = 1; cyc();
    chk("R1 reset after run", {w_q, x_q}, 12'h000);
    rst = 0;
  endtask

  initial begin
    idle();
    t_reset();
    t_field();
    t_sel_sweep(8'b1010_0110);
    t_sel_sweep(8'b0101_1001);
    t_emit_hold();
    t_imm();
    t_restore();
    t_force();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule